// File: doc/BRIEF.md
# Matrix Engine Instruction Sequencer

This block runs a short program of 16-bit matrix instructions. It holds the program in a small internal instruction store that is written through a simple write port. After a synchronous `start` pulse it steps through the program from slot 0. Each instruction is decoded into a one-cycle start strobe for one of five datapath units: row-buffer load, column-buffer load, systolic multiply, activation, and store to data memory. The address, row and column operands go out with the strobe. The sequencer then waits until that unit returns its done pulse, and only then moves to the next slot.

Execution ends when the program counter reaches the programmed instruction count, and the block then reports that it is halted. Two sticky flags record problems in the program. One is set by an undefined opcode. The other is set when an activation or a store is issued before any multiply has finished. Neither flag stops execution, and the next `start` clears both.

Top module: `mx_sequencer`

## Requirements
- R1: While reset is held, and after it is released with no `start`, every strobe, `busy`, `halted`, `illegal_seen` and `order_err` is low.
- R2: An instruction word is split into opcode in bits [15:12], address in [11:8], row count in [7:4] and column count in [3:0]. Those three operand fields appear on `op_addr`, `op_rows` and `op_cols` in the same cycle as the strobe.
- R3: Opcode 0010 strobes `ldr_start` and opcode 0011 strobes `ldc_start`. Opcode 0100 strobes `mm_start` and opcode 0001 strobes `str_start`. Opcodes 0101 and 0110 strobe `act_start`, with `act_relu` at 1 for 0101 and at 0 for 0110.
- R4: Every strobe lasts exactly one cycle, and at most one strobe is high in any cycle.
- R5: From the strobe until the matching done pulse, `busy` stays high and the operand outputs do not change. A done pulse from any other unit is ignored, and no new instruction is issued.
- R6: Opcode 0100 issues its strobe whatever its operand bits hold.
- R7: Opcode 0000 issues no strobe and moves on to the next slot.
- R8: An opcode from 0111 to 1111 behaves like 0000 and sets `illegal_seen`. The flag stays set until the next `start`.
- R9: Opcodes 0101, 0110 and 0001 set `order_err` if no multiply has finished since the last `start`. The instruction is still issued, and the flag stays set until the next `start`.
- R10: When the program counter reaches `instr_count` (or the store depth), `halted` goes high. After that no strobe is issued, even if done pulses arrive. A count of 0 halts without issuing anything.
- R11: `start` sets the program counter back to slot 0 and clears `halted`, `illegal_seen`, `order_err` and the record of a finished multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous restart from slot 0 |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 4 | Instruction store write slot |
| prog_data | input | 16 | Instruction word to write |
| instr_count | input | 5 | Number of slots to execute |
| ldr_start | output | 1 | Row-buffer load strobe |
| ldc_start | output | 1 | Column-buffer load strobe |
| mm_start | output | 1 | Systolic multiply strobe |
| act_start | output | 1 | Activation strobe |
| act_relu | output | 1 | Activation mode: 1 rectify, 0 pass |
| str_start | output | 1 | Store-to-memory strobe |
| op_addr | output | 4 | Memory address operand |
| op_rows | output | 4 | Row count operand |
| op_cols | output | 4 | Column count operand |
| ldr_done | input | 1 | Row-buffer load finished |
| ldc_done | input | 1 | Column-buffer load finished |
| mm_done | input | 1 | Multiply finished |
| act_done | input | 1 | Activation finished |
| str_done | input | 1 | Store finished |
| busy | output | 1 | Waiting for a unit's done |
| halted | output | 1 | Program finished |
| illegal_seen | output | 1 | Sticky undefined-opcode flag |
| order_err | output | 1 | Sticky activation/store-before-multiply flag |

## Verification
A wrong pending-unit record shows up in one of two ways. Either `busy` stays high after the correct done pulse, or the next strobe appears one cycle after a done pulse from the wrong unit. A program counter that is off by one issues the wrong strobe or the wrong operands in the first issue cycle after the slip. A lost or missing sticky flag is visible on its output pin within one cycle of the offending slot, and again at halt. A halt decision that comes too early or too late changes the number of strobes, which the bench counts over the whole program.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  localparam int INSTR_W   = 16;
  localparam int FIELD_W   = 4;
  localparam int NUM_UNITS = 5;

  // one-hot unit positions
  localparam int U_LDR = 0;
  localparam int U_LDC = 1;
  localparam int U_MM  = 2;
  localparam int U_ACT = 3;
  localparam int U_STR = 4;

  typedef enum logic [3:0] {
    OP_NOP  = 4'b0000,
    OP_STR  = 4'b0001,
    OP_LDR  = 4'b0010,
    OP_LDC  = 4'b0011,
    OP_MUL  = 4'b0100,
    OP_RELU = 4'b0101,
    OP_LIN  = 4'b0110
  } mx_op_e;

  typedef struct packed {
    logic [FIELD_W-1:0] addr;
    logic [FIELD_W-1:0] rows;
    logic [FIELD_W-1:0] cols;
  } mx_operands_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EXEC = 2'd1,
    S_WAIT = 2'd2,
    S_HALT = 2'd3
  } mx_state_e;
endpackage

// File: rtl/mseq_rst_sync.sv
module mseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mseq_imem.sv
module mseq_imem #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) slot_q[g] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/mseq_decode.sv
module mseq_decode
  import mseq_pkg::*;
(
  input  logic [INSTR_W-1:0]   instr,
  output logic [NUM_UNITS-1:0] unit_oh,
  output logic                 relu,
  output logic                 illegal,
  output logic                 needs_mul,
  output mx_operands_t         fields
);
  logic [3:0] opc;

  assign opc         = instr[15:12];
  assign fields.addr = instr[11:8];
  assign fields.rows = instr[7:4];
  assign fields.cols = instr[3:0];

  always_comb begin
    unit_oh   = '0;
    relu      = 1'b0;
    illegal   = 1'b0;
    needs_mul = 1'b0;
    case (opc)
      OP_NOP:  ;
      OP_LDR:  unit_oh[U_LDR] = 1'b1;
      OP_LDC:  unit_oh[U_LDC] = 1'b1;
      OP_MUL:  unit_oh[U_MM]  = 1'b1;
      OP_RELU: begin unit_oh[U_ACT] = 1'b1; relu = 1'b1; needs_mul = 1'b1; end
      OP_LIN:  begin unit_oh[U_ACT] = 1'b1; needs_mul = 1'b1; end
      OP_STR:  begin unit_oh[U_STR] = 1'b1; needs_mul = 1'b1; end
      default: illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CNT_W-1:0]     instr_count,
  input  logic [NUM_UNITS-1:0] dec_unit,
  input  logic                 dec_relu,
  input  logic                 dec_illegal,
  input  logic                 dec_needs_mul,
  input  mx_operands_t         dec_fields,
  input  logic [NUM_UNITS-1:0] done_vec,
  output logic [CNT_W-1:0]     pc,
  output logic [NUM_UNITS-1:0] strobe,
  output mx_operands_t         ops,
  output logic                 act_relu,
  output logic                 busy,
  output logic                 halted,
  output logic                 illegal_seen,
  output logic                 order_err
);
  mx_state_e            state_q, state_d;
  logic [CNT_W-1:0]     pc_q, pc_d;
  logic [NUM_UNITS-1:0] strb_q, strb_d;
  logic [NUM_UNITS-1:0] pend_q, pend_d;
  logic                 ill_q, ill_d, ord_q, ord_d, mul_seen_q, mul_seen_d;
  mx_operands_t         ops_q;
  logic                 relu_q;
  logic                 issue_en;
  logic                 end_of_prog;

  assign end_of_prog = (pc_q >= instr_count) || (pc_q == CNT_W'(DEPTH));

  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    strb_d     = '0;
    pend_d     = pend_q;
    ill_d      = ill_q;
    ord_d      = ord_q;
    mul_seen_d = mul_seen_q;
    issue_en   = 1'b0;
    if (start) begin
      state_d    = S_EXEC;
      pc_d       = '0;
      pend_d     = '0;
      ill_d      = 1'b0;
      ord_d      = 1'b0;
      mul_seen_d = 1'b0;
    end else begin
      case (state_q)
        S_EXEC: begin
          if (end_of_prog) begin
            state_d = S_HALT;
          end else if (dec_unit == '0) begin
            pc_d = pc_q + 1'b1;
            if (dec_illegal) ill_d = 1'b1;
          end else begin
            issue_en = 1'b1;
            strb_d   = dec_unit;
            pend_d   = dec_unit;
            state_d  = S_WAIT;
            if (dec_needs_mul && !mul_seen_q) ord_d = 1'b1;
          end
        end
        S_WAIT: begin
          if (|(pend_q & done_vec)) begin
            pc_d    = pc_q + 1'b1;
            state_d = S_EXEC;
            if (pend_q[U_MM]) mul_seen_d = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      pc_q       <= '0;
      strb_q     <= '0;
      pend_q     <= '0;
      ill_q      <= 1'b0;
      ord_q      <= 1'b0;
      mul_seen_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      pc_q       <= pc_d;
      strb_q     <= strb_d;
      pend_q     <= pend_d;
      ill_q      <= ill_d;
      ord_q      <= ord_d;
      mul_seen_q <= mul_seen_d;
    end
  end

  // operand and mode registers load only on issue
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ops_q  <= '0;
      relu_q <= 1'b0;
    end else if (issue_en) begin
      ops_q  <= dec_fields;
      if (dec_unit[U_ACT]) relu_q <= dec_relu;
    end
  end

  assign pc           = pc_q;
  assign strobe       = strb_q;
  assign ops          = ops_q;
  assign act_relu     = relu_q;
  assign busy         = (state_q == S_WAIT);
  assign halted       = (state_q == S_HALT);
  assign illegal_seen = ill_q;
  assign order_err    = ord_q;
endmodule

// File: rtl/mx_sequencer.sv
module mx_sequencer
  import mseq_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int PC_W  = $clog2(DEPTH),
  localparam int CNT_W = PC_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               prog_we,
  input  logic [PC_W-1:0]    prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic [CNT_W-1:0]   instr_count,
  output logic               ldr_start,
  output logic               ldc_start,
  output logic               mm_start,
  output logic               act_start,
  output logic               act_relu,
  output logic               str_start,
  output logic [FIELD_W-1:0] op_addr,
  output logic [FIELD_W-1:0] op_rows,
  output logic [FIELD_W-1:0] op_cols,
  input  logic               ldr_done,
  input  logic               ldc_done,
  input  logic               mm_done,
  input  logic               act_done,
  input  logic               str_done,
  output logic               busy,
  output logic               halted,
  output logic               illegal_seen,
  output logic               order_err
);
  logic                 rst_n_int;
  logic [CNT_W-1:0]     pc;
  logic [INSTR_W-1:0]   cur_instr;
  logic [NUM_UNITS-1:0] dec_unit, strobe, done_vec;
  logic                 dec_relu, dec_illegal, dec_needs_mul;
  mx_operands_t         dec_fields, ops;

  mseq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  mseq_imem #(.DEPTH(DEPTH), .WORD_W(INSTR_W)) u_imem (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
    .raddr(pc[PC_W-1:0]), .rdata(cur_instr)
  );

  mseq_decode u_dec (
    .instr(cur_instr), .unit_oh(dec_unit), .relu(dec_relu),
    .illegal(dec_illegal), .needs_mul(dec_needs_mul), .fields(dec_fields)
  );

  assign done_vec[U_LDR] = ldr_done;
  assign done_vec[U_LDC] = ldc_done;
  assign done_vec[U_MM]  = mm_done;
  assign done_vec[U_ACT] = act_done;
  assign done_vec[U_STR] = str_done;

  mseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .start(start), .instr_count(instr_count),
    .dec_unit(dec_unit), .dec_relu(dec_relu), .dec_illegal(dec_illegal),
    .dec_needs_mul(dec_needs_mul), .dec_fields(dec_fields),
    .done_vec(done_vec), .pc(pc), .strobe(strobe), .ops(ops),
    .act_relu(act_relu), .busy(busy), .halted(halted),
    .illegal_seen(illegal_seen), .order_err(order_err)
  );

  assign ldr_start = strobe[U_LDR];
  assign ldc_start = strobe[U_LDC];
  assign mm_start  = strobe[U_MM];
  assign act_start = strobe[U_ACT];
  assign str_start = strobe[U_STR];
  assign op_addr   = ops.addr;
  assign op_rows   = ops.rows;
  assign op_cols   = ops.cols;
endmodule

// File: rtl/mx_sequencer_chk.sv
module mx_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [4:0] stb,
  input logic [3:0] op_addr,
  input logic [3:0] op_rows,
  input logic [3:0] op_cols,
  input logic       busy,
  input logic       halted,
  input logic       illegal_seen,
  input logic       order_err
);
  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb));

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stb) |=> (stb == 5'd0));

  // R5
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start)) |-> $stable({op_addr, op_rows, op_cols}));

  // R10
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (stb == 5'd0));

  // R8
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(illegal_seen) && !$past(start)) |-> illegal_seen);

  // R9
  order_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(order_err) && !$past(start)) |-> order_err);

  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (!illegal_seen && !order_err && !halted));
endmodule

bind mx_sequencer mx_sequencer_chk u_mx_sequencer_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .stb({str_start, act_start, mm_start, ldc_start, ldr_start}),
  .op_addr(op_addr), .op_rows(op_rows), .op_cols(op_cols),
  .busy(busy), .halted(halted), .illegal_seen(illegal_seen),
  .order_err(order_err)
);

// File: tb/test_mx_sequencer.sv
module test_mx_sequencer;
  localparam int U_LDR = 0, U_LDC = 1, U_MM = 2, U_ACT = 3, U_STR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        prog_we = 1'b0;
  logic [3:0]  prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic [4:0]  instr_count = '0;
  logic [4:0]  done_v = '0;
  logic        ldr_start, ldc_start, mm_start, act_start, act_relu, str_start;
  logic [3:0]  op_addr, op_rows, op_cols;
  logic        busy, halted, illegal_seen, order_err;
  logic [4:0]  stb;

  int checks = 0;
  int failures = 0;
  int strobe_total = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mx_sequencer i_mx_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data), .instr_count(instr_count),
    .ldr_start(ldr_start), .ldc_start(ldc_start), .mm_start(mm_start),
    .act_start(act_start), .act_relu(act_relu), .str_start(str_start),
    .op_addr(op_addr), .op_rows(op_rows), .op_cols(op_cols),
    .ldr_done(done_v[U_LDR]), .ldc_done(done_v[U_LDC]), .mm_done(done_v[U_MM]),
    .act_done(done_v[U_ACT]), .str_done(done_v[U_STR]),
    .busy(busy), .halted(halted), .illegal_seen(illegal_seen), .order_err(order_err)
  );

  assign stb = {str_start, act_start, mm_start, ldc_start, ldr_start};

  always @(negedge clk) if (stb != 5'd0) strobe_total++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int slot, input logic [15:0] word);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 4'(slot); prog_data = word;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic kick(input int count);
    @(negedge clk);
    instr_count = 5'(count);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // wait for the next strobe, check it and its operands, hold, then return done
  task automatic serve(input int unit, input logic [3:0] a, input logic [3:0] r,
                       input logic [3:0] c, input bit relu, input int hold, input string req);
    int n = 0;
    while (stb == 5'd0 && n < 40) begin @(negedge clk); n++; end
    chk({req, " R3 strobe"}, 32'(stb), 32'(1 << unit));
    chk({req, " R2 operands"}, {20'd0, op_addr, op_rows, op_cols}, {20'd0, a, r, c});
    if (unit == U_ACT) chk({req, " R3 act mode"}, 32'(act_relu), 32'(relu));
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk({req, " R4 strobe dropped"}, 32'(stb), 32'd0);
      chk({req, " R5 operands held"}, {20'd0, op_addr, op_rows, op_cols}, {20'd0, a, r, c});
      chk({req, " R5 busy"}, 32'(busy), 32'd1);
    end
    done_v[unit] = 1'b1;
    @(negedge clk);
    done_v = '0;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 10) begin @(negedge clk); n++; end
    chk({req, " R10 halted"}, 32'(halted), 32'd1);
  endtask

  task automatic t_reset;
    chk("R1 strobes in reset", 32'(stb), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 strobes", 32'(stb), 32'd0);
    chk("R1 flags", {busy, halted, illegal_seen, order_err}, 32'd0);
  endtask

  task automatic t_main_flow;
    int base;
    load(0, 16'h2324);   // LDR a3 r2 c4
    load(1, 16'h3542);   // LDC a5 r4 c2
    load(2, 16'h4FFF);   // MATMUL, fields set (R6)
    load(3, 16'h5000);   // RELU
    load(4, 16'h1922);   // STR a9 r2 c2
    base = strobe_total;
    kick(5);
    serve(U_LDR, 4'h3, 4'h2, 4'h4, 0, 2, "main ldr");
    serve(U_LDC, 4'h5, 4'h4, 4'h2, 0, 1, "main ldc");
    serve(U_MM,  4'hF, 4'hF, 4'hF, 0, 3, "main R6 mul");
    serve(U_ACT, 4'h0, 4'h0, 4'h0, 1, 1, "main relu");
    serve(U_STR, 4'h9, 4'h2, 4'h2, 0, 1, "main str");
    wait_halt("main");
    chk("main R9 no order error", 32'(order_err), 32'd0);
    chk("main R8 no illegal", 32'(illegal_seen), 32'd0);
    chk("main R10 strobe count", 32'(strobe_total - base), 32'd5);
    repeat (3) begin
      done_v = 5'h1F; @(negedge clk); done_v = '0; @(negedge clk);
    end
    chk("main R10 quiet after halt", 32'(strobe_total - base), 32'd5);
  endtask

  task automatic t_nop_illegal;
    int base;
    load(0, 16'h0ABC);   // NOP
    load(1, 16'h7123);   // undefined
    load(2, 16'hF456);   // undefined
    load(3, 16'h6789);   // LIN before any multiply
    base = strobe_total;
    kick(4);
    chk("nop R11 flags cleared", {illegal_seen, order_err, halted}, 32'd0);
    serve(U_ACT, 4'h7, 4'h8, 4'h9, 0, 1, "nop R7 lin");
    chk("nop R8 illegal flag", 32'(illegal_seen), 32'd1);
    chk("nop R9 order flag", 32'(order_err), 32'd1);
    wait_halt("nop");
    chk("nop R7 only one strobe", 32'(strobe_total - base), 32'd1);
    chk("nop R8 flag sticky", 32'(illegal_seen), 32'd1);
  endtask

  task automatic t_restart;
    int base;
    kick(0);
    chk("restart R11 illegal cleared", 32'(illegal_seen), 32'd0);
    chk("restart R11 order cleared", 32'(order_err), 32'd0);
    chk("restart R11 halted cleared", 32'(halted), 32'd0);
    base = strobe_total;
    wait_halt("restart count zero");
    chk("restart R10 no strobe", 32'(strobe_total - base), 32'd0);
    load(0, 16'h1321);   // STR before multiply
    load(1, 16'h4000);
    load(2, 16'h1654);   // STR after multiply
    kick(3);
    serve(U_STR, 4'h3, 4'h2, 4'h1, 0, 1, "restart R11 slot0");
    chk("restart R9 store before mul", 32'(order_err), 32'd1);
    serve(U_MM, 4'h0, 4'h0, 4'h0, 0, 1, "restart mul");
    serve(U_STR, 4'h6, 4'h5, 4'h4, 0, 1, "restart str2");
    wait_halt("restart");
    kick(3);
    serve(U_STR, 4'h3, 4'h2, 4'h1, 0, 1, "again R11 slot0");
    chk("again R11 mul record cleared", 32'(order_err), 32'd1);
    serve(U_MM, 4'h0, 4'h0, 4'h0, 0, 1, "again mul");
    serve(U_STR, 4'h6, 4'h5, 4'h4, 0, 1, "again str2");
    wait_halt("again");
  endtask

  task automatic t_wrong_done;
    int base;
    load(0, 16'h2ABC);
    load(1, 16'h3DEF);
    base = strobe_total;
    kick(2);
    while (stb == 5'd0) @(negedge clk);
    chk("wrong R3 ldr strobe", 32'(stb), 32'(1 << U_LDR));
    @(negedge clk);
    done_v = 5'b11110;   // every unit except the pending one
    @(negedge clk);
    done_v = '0;
    repeat (4) @(negedge clk);
    chk("wrong R5 still busy", 32'(busy), 32'd1);
    chk("wrong R5 no new strobe", 32'(strobe_total - base), 32'd1);
    chk("wrong R5 operands", {20'd0, op_addr, op_rows, op_cols}, 32'h00000ABC);
    done_v[U_LDR] = 1'b1;
    @(negedge clk);
    done_v = '0;
    serve(U_LDC, 4'hD, 4'hE, 4'hF, 0, 1, "wrong R5 next");
    wait_halt("wrong");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_main_flow();
    t_nop_illegal();
    t_restart();
    t_wrong_done();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R10 actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule